// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block turns the bus write cycles aimed at one NOR-style flash bank into program commands. It follows the four-write standard program sequence (two unlock writes, a setup write, then the target address and data). It also handles a bypass mode in which the unlock pair is skipped, so each program needs only a command write and a data write. Bypass mode is entered with a dedicated third unlock write or by holding the accelerate input. It is left only through its own two-write reset.

An accepted program starts a fixed-latency busy period that stands in for the embedded algorithm. While that period runs, every write is ignored. When it ends, the addressed word of a small array model is updated. That model can only clear bits. An attempt to raise a cleared bit leaves the bit at 0 and sets an overwrite error flag. An asynchronous hardware reset aborts any running program and returns the decoder to read mode. A peek port exposes array words so the result of each program can be observed.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While and after reset: prog_req, busy, bypass_mode and overwrite_err are 0, and every array word reads all ones (FFh).
- R2: Four writes start a standard program: 0555h/AAh, 02AAh/55h, 0555h/A0h, then any address with data. prog_req is high only in the cycle after the last write. busy is high from that cycle for PROG_CYCLES cycles.
- R3: In the cycle in which busy falls, the word at index addr[ARR_AW-1:0] of the programmed address reads old AND new data.
- R4: A write that is not the expected next step of a standard sequence returns the decoder to read mode. A following setup write and data write then program nothing.
- R5: The writes 0555h/AAh, 02AAh/55h, 0555h/20h set bypass_mode in the cycle after the third write.
- R6: In bypass mode, a write of data A0h at any address followed by a data write starts a program with the R2 timing. bypass_mode stays 1 through and after it.
- R7: In bypass mode, writes with data other than A0h and 90h are ignored. This includes the standard unlock writes: they neither program nor leave bypass.
- R8: Bypass mode is left by a write of 90h followed by a write of 00h. bypass_mode is 0 in the cycle after the 00h write. A 90h write followed by any other data keeps bypass mode.
- R9: Writes while busy is high are ignored. They produce no prog_req and leave no partial sequence behind.
- R10: Driving rst_n low during a program drops busy and bypass_mode at once, without waiting for a clock edge. After release the decoder is in read mode.
- R11: When a program would turn a 0 bit into 1, overwrite_err is 1 from the cycle busy falls, and that bit stays 0. The flag holds until the next accepted program, which clears it in its prog_req cycle.
- R12: With acc high and busy low, bypass_mode is 1 in the next cycle. It stays 1 after acc returns low, until the R8 exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| we | input | 1 | One-cycle bus write strobe |
| addr | input | ADDR_W | Write address |
| wdata | input | DATA_W | Write data, command code in bits 7:0 |
| acc | input | 1 | Accelerate pin, forces bypass mode |
| peek_addr | input | ARR_AW | Array word index to observe |
| peek_data | output | DATA_W | Array word at peek_addr |
| prog_req | output | 1 | One-cycle pulse when a program is accepted |
| busy | output | 1 | Program operation running |
| bypass_mode | output | 1 | Decoder in unlock bypass mode |
| overwrite_err | output | 1 | Last program tried to set a cleared bit |

## Verification
The decoder is driven with complete standard sequences, sequences broken at their second step, and bypass entries reached both by the 20h command and by the accelerate pin. Replaying the unlock pair inside bypass mode shows that standard commands are refused there. A stray unlock write during busy, followed by the rest of a sequence, shows whether the busy window really discards writes or quietly advances the decoder. Programming the same word twice with complementary data separates clear-only behaviour and the error flag from a plain overwrite. An abort by reset mid-program, followed by a bypass-only command, confirms the return to read mode.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        ST_READ      = 3'd0,
        ST_UNL1      = 3'd1,
        ST_UNL2      = 3'd2,
        ST_SETUP     = 3'd3,
        ST_PROG      = 3'd4,
        ST_BYP_IDLE  = 3'd5,
        ST_BYP_SETUP = 3'd6,
        ST_BYP_RST1  = 3'd7
    } seq_state_e;

    localparam logic [10:0] KEY_ADDR_A = 11'h555;
    localparam logic [10:0] KEY_ADDR_B = 11'h2AA;

    localparam logic [7:0] CODE_KEY_A      = 8'hAA;
    localparam logic [7:0] CODE_KEY_B      = 8'h55;
    localparam logic [7:0] CODE_PROGRAM    = 8'hA0;
    localparam logic [7:0] CODE_BYP_ENTER  = 8'h20;
    localparam logic [7:0] CODE_BYP_LEAVE1 = 8'h90;
    localparam logic [7:0] CODE_BYP_LEAVE2 = 8'h00;

endpackage

// File: rtl/fcd_busy_timer.sv
module fcd_busy_timer #(
    parameter int PROG_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CNT_W'(PROG_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CNT_W'(1));

    AST_START_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o); // R9

endmodule

// File: rtl/fcd_array.sv
module fcd_array #(
    parameter int DATA_W = 8,
    parameter int ARR_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              clr_err_i,
    input  logic [ARR_AW-1:0] idx_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ARR_AW-1:0] peek_idx_i,
    output logic [DATA_W-1:0] peek_data_o,
    output logic              err_o
);
    localparam int DEPTH = 1 << ARR_AW;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              err_d, err_q;

    always_comb begin
        mem_d = mem_q;
        err_d = err_q;
        if (clr_err_i) begin
            err_d = 1'b0;
        end
        if (commit_i) begin
            mem_d[idx_i] = mem_q[idx_i] & data_i;
            if ((data_i & ~mem_q[idx_i]) != '0) begin
                err_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
            err_q <= 1'b0;
        end else begin
            mem_q <= mem_d;
            err_q <= err_d;
        end
    end

    assign peek_data_o = mem_q[peek_idx_i];
    assign err_o       = err_q;

    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> ((mem_q[$past(idx_i)] & ~$past(mem_q[idx_i])) == '0)); // R3

    AST_ERR_ON_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && ((data_i & ~mem_q[idx_i]) != '0)) |=> err_o); // R11

endmodule

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int ARR_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              acc_i,
    input  logic              busy_i,
    input  logic              done_i,
    output logic              start_o,
    output logic              prog_req_o,
    output logic              bypass_o,
    output logic [ARR_AW-1:0] pa_o,
    output logic [DATA_W-1:0] pd_o
);
    localparam logic [ADDR_W-1:0] ADDR_A = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] ADDR_B = ADDR_W'(KEY_ADDR_B);

    typedef struct packed {
        seq_state_e        state;
        logic              ret_byp;
        logic              req;
        logic [ARR_AW-1:0] pa;
        logic [DATA_W-1:0] pd;
    } seq_t;

    seq_t       seq_d, seq_q;
    logic [7:0] code;

    function automatic logic in_bypass(input seq_state_e st, input logic rb);
        return (st == ST_BYP_IDLE) || (st == ST_BYP_SETUP) ||
               (st == ST_BYP_RST1) || ((st == ST_PROG) && rb);
    endfunction

    assign code = wdata_i[7:0];

    always_comb begin
        seq_d   = seq_q;
        seq_d.req = 1'b0;
        start_o = 1'b0;
        if (seq_q.state == ST_PROG) begin
            if (done_i) begin
                seq_d.state = seq_q.ret_byp ? ST_BYP_IDLE : ST_READ;
            end
        end else begin
            if (we_i) begin
                case (seq_q.state)
                    ST_READ: begin
                        if (addr_i == ADDR_A && code == CODE_KEY_A) seq_d.state = ST_UNL1;
                    end
                    ST_UNL1: begin
                        seq_d.state = (addr_i == ADDR_B && code == CODE_KEY_B) ? ST_UNL2 : ST_READ;
                    end
                    ST_UNL2: begin
                        if (addr_i == ADDR_A && code == CODE_PROGRAM) begin
                            seq_d.state = ST_SETUP;
                        end else if (addr_i == ADDR_A && code == CODE_BYP_ENTER) begin
                            seq_d.state = ST_BYP_IDLE;
                        end else begin
                            seq_d.state = ST_READ;
                        end
                    end
                    ST_BYP_IDLE: begin
                        if (code == CODE_PROGRAM) begin
                            seq_d.state = ST_BYP_SETUP;
                        end else if (code == CODE_BYP_LEAVE1) begin
                            seq_d.state = ST_BYP_RST1;
                        end
                    end
                    ST_BYP_RST1: begin
                        seq_d.state = (code == CODE_BYP_LEAVE2) ? ST_READ : ST_BYP_IDLE;
                    end
                    ST_SETUP, ST_BYP_SETUP: begin
                        start_o       = 1'b1;
                        seq_d.req     = 1'b1;
                        seq_d.state   = ST_PROG;
                        seq_d.ret_byp = (seq_q.state == ST_BYP_SETUP) || acc_i;
                        seq_d.pa      = addr_i[ARR_AW-1:0];
                        seq_d.pd      = wdata_i;
                    end
                    default: seq_d.state = ST_READ;
                endcase
            end
            if (acc_i && (seq_d.state != ST_PROG) && !in_bypass(seq_d.state, 1'b0)) begin
                seq_d.state = ST_BYP_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state   <= ST_READ;
            seq_q.ret_byp <= 1'b0;
            seq_q.req     <= 1'b0;
            seq_q.pa      <= '0;
            seq_q.pd      <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign prog_req_o = seq_q.req;
    assign bypass_o   = in_bypass(seq_q.state, seq_q.ret_byp);
    assign pa_o       = seq_q.pa;
    assign pd_o       = seq_q.pd;

    AST_PROG_TRACKS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_PROG) == busy_i); // R9

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |=> !prog_req_o); // R2

    AST_BYP_EXIT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bypass_o) |-> $past(seq_q.state == ST_BYP_RST1 && we_i &&
                                  code == CODE_BYP_LEAVE2 && !acc_i)); // R8

    AST_ACC_FORCES_BYP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !busy_i) |=> bypass_o); // R12

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int ARR_AW      = 4,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              acc,
    input  logic [ARR_AW-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic              prog_req,
    output logic              busy,
    output logic              bypass_mode,
    output logic              overwrite_err
);
    logic              start, done;
    logic [ARR_AW-1:0] pa;
    logic [DATA_W-1:0] pd;

    fcd_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ARR_AW (ARR_AW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (we),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .acc_i      (acc),
        .busy_i     (busy),
        .done_i     (done),
        .start_o    (start),
        .prog_req_o (prog_req),
        .bypass_o   (bypass_mode),
        .pa_o       (pa),
        .pd_o       (pd)
    );

    fcd_busy_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .done_o  (done)
    );

    fcd_array #(
        .DATA_W (DATA_W),
        .ARR_AW (ARR_AW)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (done),
        .clr_err_i   (start),
        .idx_i       (pa),
        .data_i      (pd),
        .peek_idx_i  (peek_addr),
        .peek_data_o (peek_data),
        .err_o       (overwrite_err)
    );

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int PC         = 3;
    localparam int NROWS      = 45;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       acc = 1'b0;
    logic [3:0] peek_addr = '0;
    logic [7:0] peek_data;
    logic       prog_req, busy, bypass_mode, overwrite_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder #(
        .ADDR_W(16), .DATA_W(8), .ARR_AW(4), .PROG_CYCLES(PC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .acc(acc),
        .peek_addr(peek_addr), .peek_data(peek_data), .prog_req(prog_req),
        .busy(busy), .bypass_mode(bypass_mode), .overwrite_err(overwrite_err)
    );

    // fields: we, addr, data, acc, peek index, exp req/busy/byp/err, exp peek, tag
    typedef struct packed {
        logic        we;
        logic [15:0] a;
        logic [7:0]  d;
        logic        acc;
        logic [3:0]  pk;
        logic        req;
        logic        bsy;
        logic        byp;
        logic        err;
        logic [7:0]  rd;
        logic [3:0]  tag;
    } vec_t;

    localparam vec_t VEC [NROWS] = '{
        '{1'b1,16'h0555,8'hAA,1'b0,4'd3,1'b0,1'b0,1'b0,1'b0,8'hFF,4'd2},  // R2
        '{1'b1,16'h02AA,8'h55,1'b0,4'd3,1'b0,1'b0,1'b0,1'b0,8'hFF,4'd2},
        '{1'b1,16'h0555,8'hA0,1'b0,4'd3,1'b0,1'b0,1'b0,1'b0,8'hFF,4'd2},
        '{1'b1,16'h1003,8'h5A,1'b0,4'd3,1'b1,1'b1,1'b0,1'b0,8'hFF,4'd2},
        '{1'b0,16'h0000,8'h00,1'b0,4'd3,1'b0,1'b1,1'b0,1'b0,8'hFF,4'd2},
        '{1'b0,16'h0000,8'h00,1'b0,4'd3,1'b0,1'b1,1'b0,1'b0,8'hFF,4'd2},
        '{1'b0,16'h0000,8'h00,1'b0,4'd3,1'b0,1'b0,1'b0,1'b0,8'h5A,4'd3},  // R3
        '{1'b1,16'h0555,8'hAA,1'b0,4'd3,1'b0,1'b0,1'b0,1'b0,8'h5A,4'd11}, // R11
        '{1'b1,16'h02AA,8'h55,1'b0,4'd3,1'b0,1'b0,1'b0,1'b0,8'h5A,4'd11},
        '{1'b1,16'h0555,8'hA0,1'b0,4'd3,1'b0,1'b0,1'b0,1'b0,8'h5A,4'd11},
        '{1'b1,16'h1003,8'hA5,1'b0,4'd3,1'b1,1'b1,1'b0,1'b0,8'h5A,4'd11},
        '{1'b0,16'h0000,8'h00,1'b0,4'd3,1'b0,1'b1,1'b0,1'b0,8'h5A,4'd11},
        '{1'b1,16'h0555,8'hAA,1'b0,4'd3,1'b0,1'b1,1'b0,1'b0,8'h5A,4'd9},  // R9
        '{1'b0,16'h0000,8'h00,1'b0,4'd3,1'b0,1'b0,1'b0,1'b1,8'h00,4'd11},
        '{1'b1,16'h02AA,8'h55,1'b0,4'd4,1'b0,1'b0,1'b0,1'b1,8'hFF,4'd9},
        '{1'b1,16'h0555,8'hA0,1'b0,4'd4,1'b0,1'b0,1'b0,1'b1,8'hFF,4'd9},
        '{1'b1,16'h1004,8'h0F,1'b0,4'd4,1'b0,1'b0,1'b0,1'b1,8'hFF,4'd9},
        '{1'b1,16'h0555,8'hAA,1'b0,4'd4,1'b0,1'b0,1'b0,1'b1,8'hFF,4'd4},  // R4
        '{1'b1,16'h02AA,8'h56,1'b0,4'd4,1'b0,1'b0,1'b0,1'b1,8'hFF,4'd4},
        '{1'b1,16'h0555,8'hA0,1'b0,4'd4,1'b0,1'b0,1'b0,1'b1,8'hFF,4'd4},
        '{1'b1,16'h1004,8'h0F,1'b0,4'd4,1'b0,1'b0,1'b0,1'b1,8'hFF,4'd4},
        '{1'b1,16'h0555,8'hAA,1'b0,4'd4,1'b0,1'b0,1'b0,1'b1,8'hFF,4'd5},  // R5
        '{1'b1,16'h02AA,8'h55,1'b0,4'd4,1'b0,1'b0,1'b0,1'b1,8'hFF,4'd5},
        '{1'b1,16'h0555,8'h20,1'b0,4'd4,1'b0,1'b0,1'b1,1'b1,8'hFF,4'd5},
        '{1'b1,16'h0555,8'hAA,1'b0,4'd4,1'b0,1'b0,1'b1,1'b1,8'hFF,4'd7},  // R7
        '{1'b1,16'h02AA,8'h55,1'b0,4'd4,1'b0,1'b0,1'b1,1'b1,8'hFF,4'd7},
        '{1'b1,16'h1004,8'h0F,1'b0,4'd4,1'b0,1'b0,1'b1,1'b1,8'hFF,4'd7},
        '{1'b1,16'h0777,8'hA0,1'b0,4'd4,1'b0,1'b0,1'b1,1'b1,8'hFF,4'd6},  // R6
        '{1'b1,16'h1004,8'hF0,1'b0,4'd4,1'b1,1'b1,1'b1,1'b0,8'hFF,4'd6},
        '{1'b0,16'h0000,8'h00,1'b0,4'd4,1'b0,1'b1,1'b1,1'b0,8'hFF,4'd6},
        '{1'b0,16'h0000,8'h00,1'b0,4'd4,1'b0,1'b1,1'b1,1'b0,8'hFF,4'd6},
        '{1'b0,16'h0000,8'h00,1'b0,4'd4,1'b0,1'b0,1'b1,1'b0,8'hF0,4'd6},
        '{1'b1,16'h0000,8'h90,1'b0,4'd4,1'b0,1'b0,1'b1,1'b0,8'hF0,4'd8},  // R8
        '{1'b1,16'h0000,8'h11,1'b0,4'd4,1'b0,1'b0,1'b1,1'b0,8'hF0,4'd8},
        '{1'b1,16'h0000,8'h90,1'b0,4'd4,1'b0,1'b0,1'b1,1'b0,8'hF0,4'd8},
        '{1'b1,16'h0000,8'h00,1'b0,4'd4,1'b0,1'b0,1'b0,1'b0,8'hF0,4'd8},
        '{1'b0,16'h0000,8'h00,1'b1,4'd5,1'b0,1'b0,1'b1,1'b0,8'hFF,4'd12}, // R12
        '{1'b0,16'h0000,8'h00,1'b0,4'd5,1'b0,1'b0,1'b1,1'b0,8'hFF,4'd12},
        '{1'b1,16'h0123,8'hA0,1'b0,4'd5,1'b0,1'b0,1'b1,1'b0,8'hFF,4'd12},
        '{1'b1,16'h1005,8'h33,1'b0,4'd5,1'b1,1'b1,1'b1,1'b0,8'hFF,4'd12},
        '{1'b0,16'h0000,8'h00,1'b0,4'd5,1'b0,1'b1,1'b1,1'b0,8'hFF,4'd12},
        '{1'b0,16'h0000,8'h00,1'b0,4'd5,1'b0,1'b1,1'b1,1'b0,8'hFF,4'd12},
        '{1'b0,16'h0000,8'h00,1'b0,4'd5,1'b0,1'b0,1'b1,1'b0,8'h33,4'd12},
        '{1'b1,16'h0000,8'h90,1'b0,4'd5,1'b0,1'b0,1'b1,1'b0,8'h33,4'd8},
        '{1'b1,16'h0000,8'h00,1'b0,4'd5,1'b0,1'b0,1'b0,1'b0,8'h33,4'd8}
    };

    task automatic check(input int tag, input logic [11:0] act, input logic [11:0] exp,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [11:0] outs();
        return {prog_req, busy, bypass_mode, overwrite_err, peek_data};
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    initial begin
        // R1: reset state, all words erased
        #(CLK_PERIOD/4);
        check(1, {8'h0, prog_req, busy, bypass_mode, overwrite_err}, 12'h0, "during reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            peek_addr = 4'(i);
            #1;
            check(1, outs(), 12'h0FF, "word after reset");
        end

        for (int r = 0; r < NROWS; r++) begin
            @(negedge clk);
            we = VEC[r].we; addr = VEC[r].a; wdata = VEC[r].d;
            acc = VEC[r].acc; peek_addr = VEC[r].pk;
            @(posedge clk);
            #(CLK_PERIOD/4);
            check(int'(VEC[r].tag), outs(),
                  {VEC[r].req, VEC[r].bsy, VEC[r].byp, VEC[r].err, VEC[r].rd},
                  $sformatf("row %0d", r));
        end
        @(negedge clk);
        we = 1'b0; acc = 1'b0;

        // R10: abort during a standard program
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
        wr(16'h0555, 8'hA0);
        @(negedge clk);
        we = 1'b1; addr = 16'h1006; wdata = 8'h00;
        @(negedge clk);
        we = 1'b0;
        check(10, {11'h0, busy}, 12'h1, "busy before abort");
        rst_n = 1'b0;
        #1;
        check(10, {8'h0, prog_req, busy, bypass_mode, overwrite_err}, 12'h0, "abort at once");
        @(negedge clk);
        rst_n = 1'b1;
        // bypass-only commands must not program in read mode
        wr(16'h0000, 8'hA0);
        @(negedge clk);
        we = 1'b1; addr = 16'h1006; wdata = 8'h00; peek_addr = 4'd6;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(10, outs(), 12'h0FF, "read mode after abort");
        @(negedge clk);
        we = 1'b0;

        // R10: reset also clears bypass entered through acc
        acc = 1'b1;
        @(negedge clk);
        acc = 1'b0;
        check(12, {11'h0, bypass_mode}, 12'h1, "acc entry");
        rst_n = 1'b0;
        #1;
        check(10, {11'h0, bypass_mode}, 12'h0, "reset leaves bypass");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule